// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers thirteen level-sensitive interrupt requests, numbered 1 to 13, and presents the most urgent one to a processor as a 3-bit interrupt level together with an 8-bit vector number. Each source owns an 8-bit control register. Its low five bits form a combined level-plus-priority key, and its top bit chooses between an autovector and an explicit vector. A mask register blocks individual sources. A read-only pending view shows the raw request lines.

Among the sources that are requesting and not masked, the one with the largest key wins. On a tie the lower-numbered source wins. A winner whose key is below 4 is not presented at all. For an explicit vector, three sources draw their number from dedicated vector registers: source 8 (software watchdog) and sources 12 and 13 (the two serial channels). All other sources fall back to a fixed default. The level and vector outputs are registered.

Software reaches all storage through a simple single-cycle register port. The port uses an 8-bit byte offset, a write strobe and 16-bit data. Reads are combinational.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset the control registers of sources 1 to 7 read 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x1C, source 8 reads 0x1C, sources 9 to 11 read 0x80, and sources 12 and 13 read 0x00. The mask reads 0x3FFE, all three vector registers read 0x0F, and the level and vector outputs are 0.
- R2: Offset 0x3A reads the request line of source i in bit i for i = 1 to 13, with bits 0, 14 and 15 reading 0. Writes to this offset change nothing.
- R3: Offset 0x36 is the mask, with bit i (1 to 13) set meaning that source i cannot win. Bits 0, 14 and 15 read 0 and are ignored on write.
- R4: The winner is the requesting, unmasked source whose control bits 4:0 are largest. On equal values the lower-numbered source wins.
- R5: When the winner's control bits 4:0 are below 4, or no source is eligible, both the level output and the vector output are 0.
- R6: The level output equals control bits 4:2 of the winner.
- R7: When control bit 7 of the winner is 1, the vector output is 24 plus the level.
- R8: When control bit 7 of the winner is 0, the vector depends on the winner. Source 8 takes the watchdog vector register (offset 0x42), source 12 takes serial-channel vector 0 (offset 0x44), source 13 takes serial-channel vector 1 (offset 0x46), and any other source gets 0x0F.
- R9: The control register of source i sits at offset 0x13+i, holds wdata bits 7:0 and reads 0 in bits 15:8. The level and vector outputs reflect a change of request, mask or any register one clock edge after that change takes effect.
- R10: Offsets outside the registers above read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 13 | Level request per source, bit i for source i |
| reg_addr | input | 8 | Register byte offset |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| ipl_o | output | 3 | Presented interrupt level, 0 when idle |
| vec_o | output | 8 | Presented vector number, 0 when idle |

## Verification
The bench builds two copies of the block with the default 13 sources and register offsets. One copy uses the sequential-scan arbiter and the other uses the comparison-tree arbiter, and both are checked against one behavioural model on every clock. Running both arbiter variants side by side puts ties between equal keys, keys just under the threshold of 4 and winners at the highest source index within reach of both selection structures. The default parameters keep the three dedicated vector sources at 8, 12 and 13, so explicit-vector lookups and autovector arithmetic are exercised at their specified positions.

// File: rtl/pvic_pkg.sv
package pvic_pkg;

   typedef enum logic {
      ARB_SCAN = 1'b0,
      ARB_TREE = 1'b1
   } arb_style_e;

   localparam int KEY_W  = 5;
   localparam int CTRL_W = 8;

   // Power-on control values per source (R1)
   function automatic logic [CTRL_W-1:0] ctrl_rst_val(input int src);
      if (src >= 1 && src <= 7)
         return CTRL_W'(src * 4);
      else if (src == 8)
         return 8'h1C;
      else if (src >= 9 && src <= 11)
         return 8'h80;
      else
         return 8'h00;
   endfunction

endpackage

// File: rtl/pvic_regs.sv
module pvic_regs #(
   parameter int         NUM_SRC       = 13,
   parameter int         AW            = 8,
   parameter int         DW            = 16,
   parameter int         CTRL_BASE     = 'h14,
   parameter int         MASK_ADDR     = 'h36,
   parameter int         PEND_ADDR     = 'h3A,
   parameter int         WDOG_VEC_ADDR = 'h42,
   parameter int         SER0_VEC_ADDR = 'h44,
   parameter int         SER1_VEC_ADDR = 'h46,
   parameter logic [7:0] VEC_RST       = 8'h0F
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_SRC:1]            req,
   input  logic [AW-1:0]               addr,
   input  logic                        we,
   input  logic [DW-1:0]               wdata,
   output logic [DW-1:0]               rdata,
   output logic [NUM_SRC:1][7:0]       ctrl_o,
   output logic [NUM_SRC:1]            mask_o,
   output logic [7:0]                  wvec_o,
   output logic [7:0]                  s0vec_o,
   output logic [7:0]                  s1vec_o
);
   import pvic_pkg::*;

   localparam logic [AW-1:0] A_MASK = AW'(MASK_ADDR);
   localparam logic [AW-1:0] A_PEND = AW'(PEND_ADDR);
   localparam logic [AW-1:0] A_WVEC = AW'(WDOG_VEC_ADDR);
   localparam logic [AW-1:0] A_S0V  = AW'(SER0_VEC_ADDR);
   localparam logic [AW-1:0] A_S1V  = AW'(SER1_VEC_ADDR);

   // Per-source control registers, each with its own reset value (R1, R9)
   for (genvar s = 1; s <= NUM_SRC; s++) begin : g_ctrl
      localparam logic [AW-1:0] A_CTRL = AW'(CTRL_BASE + s - 1);
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= ctrl_rst_val(s);
         else if (we && addr == A_CTRL)
            q <= wdata[7:0];
      end
      assign ctrl_o[s] = q;
   end

   // Mask keeps only the source bits; the rest read back 0 (R3)
   logic [NUM_SRC:1] mask_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mask_q <= '1;
      else if (we && addr == A_MASK)
         mask_q <= wdata[NUM_SRC:1];
   end
   assign mask_o = mask_q;

   // Dedicated vector registers (R8)
   logic [7:0] wvec_q, s0vec_q, s1vec_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wvec_q  <= VEC_RST;
         s0vec_q <= VEC_RST;
         s1vec_q <= VEC_RST;
      end else if (we) begin
         if (addr == A_WVEC) wvec_q  <= wdata[7:0];
         if (addr == A_S0V)  s0vec_q <= wdata[7:0];
         if (addr == A_S1V)  s1vec_q <= wdata[7:0];
      end
   end
   assign wvec_o  = wvec_q;
   assign s0vec_o = s0vec_q;
   assign s1vec_o = s1vec_q;

   // Wdata bits never stored anywhere
   logic unused_wdata;
   if (DW > NUM_SRC + 1) begin : g_wd_hi
      assign unused_wdata = ^{wdata[DW-1:NUM_SRC+1], wdata[0]};
   end else begin : g_wd_lo
      assign unused_wdata = wdata[0];
   end

   // Combinational read mux; unmapped offsets return 0 (R2, R10)
   always_comb begin
      rdata = '0;
      for (int s = 1; s <= NUM_SRC; s++) begin
         if (addr == AW'(CTRL_BASE + s - 1))
            rdata[7:0] = ctrl_o[s];
      end
      if (addr == A_MASK) rdata[NUM_SRC:1] = mask_q;
      if (addr == A_PEND) rdata[NUM_SRC:1] = req;
      if (addr == A_WVEC) rdata[7:0] = wvec_q;
      if (addr == A_S0V)  rdata[7:0] = s0vec_q;
      if (addr == A_S1V)  rdata[7:0] = s1vec_q;
   end

endmodule

// File: rtl/pvic_arb.sv
module pvic_arb #(
   parameter int                   NUM_SRC = 13,
   parameter int                   IW      = 4,
   parameter pvic_pkg::arb_style_e ARB     = pvic_pkg::ARB_SCAN
) (
   input  logic [NUM_SRC:1]                      active,
   input  logic [NUM_SRC:1][pvic_pkg::KEY_W-1:0] keys,
   output logic [pvic_pkg::KEY_W-1:0]            best_key,
   output logic [IW-1:0]                         best_idx
);
   import pvic_pkg::*;

   localparam int LEAVES = 1 << IW;

   if (ARB == ARB_SCAN) begin : g_scan
      // Ascending scan, strict compare: lower index keeps ties (R4)
      always_comb begin
         best_key = '0;
         best_idx = '0;
         for (int s = 1; s <= NUM_SRC; s++) begin
            if (active[s] && keys[s] > best_key) begin
               best_key = keys[s];
               best_idx = IW'(s);
            end
         end
      end
   end else begin : g_tree
      // Heap-ordered tree; left subtree always holds lower indices (R4)
      for (genvar k = 2 * LEAVES - 1; k >= 1; k--) begin : g_n
         logic [KEY_W-1:0] key;
         logic [IW-1:0]    idx;
         if (k >= LEAVES) begin : g_leaf
            localparam int J = k - LEAVES;
            if (J >= 1 && J <= NUM_SRC) begin : g_src
               assign key = active[J] ? keys[J] : '0;
            end else begin : g_pad
               assign key = '0;
            end
            assign idx = IW'(J);
         end else begin : g_cmp
            logic take_r;
            assign take_r = g_n[2*k+1].key > g_n[2*k].key;
            assign key    = take_r ? g_n[2*k+1].key : g_n[2*k].key;
            assign idx    = take_r ? g_n[2*k+1].idx : g_n[2*k].idx;
         end
      end
      assign best_key = g_n[1].key;
      assign best_idx = g_n[1].idx;
   end

endmodule

// File: rtl/pvic_present.sv
module pvic_present #(
   parameter int         NUM_SRC      = 13,
   parameter int         IW           = 4,
   parameter int         LVL_THRESH   = 4,
   parameter int         AUTOVEC_BASE = 24,
   parameter logic [7:0] DEFAULT_VEC  = 8'h0F,
   parameter int         WDOG_SRC     = 8,
   parameter int         SER0_SRC     = 12,
   parameter int         SER1_SRC     = 13
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [pvic_pkg::KEY_W-1:0]    best_key,
   input  logic [IW-1:0]                 best_idx,
   input  logic [NUM_SRC:1][7:0]         ctrl,
   input  logic [7:0]                    wvec,
   input  logic [7:0]                    s0vec,
   input  logic [7:0]                    s1vec,
   output logic                          win_valid,
   output logic                          win_auto,
   output logic [2:0]                    ipl_o,
   output logic [7:0]                    vec_o
);
   import pvic_pkg::*;

   logic [7:0] win_ctrl;
   logic [2:0] lvl;
   logic [7:0] vec_d;

   always_comb begin
      win_ctrl = '0;
      for (int s = 1; s <= NUM_SRC; s++) begin
         if (best_idx == IW'(s)) win_ctrl = ctrl[s];
      end
   end

   // Below-threshold winners are not presented (R5)
   assign win_valid = best_key >= KEY_W'(LVL_THRESH);
   assign win_auto  = win_ctrl[7];
   assign lvl       = win_ctrl[4:2];  // R6

   logic unused_ctrl;
   assign unused_ctrl = ^{win_ctrl[6:5], win_ctrl[1:0]};

   // Vector source selection (R7, R8)
   always_comb begin
      if (win_auto)
         vec_d = 8'(AUTOVEC_BASE) + {5'd0, lvl};
      else if (best_idx == IW'(WDOG_SRC))
         vec_d = wvec;
      else if (best_idx == IW'(SER0_SRC))
         vec_d = s0vec;
      else if (best_idx == IW'(SER1_SRC))
         vec_d = s1vec;
      else
         vec_d = DEFAULT_VEC;
   end

   // Registered presentation (R9)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ipl_o <= '0;
         vec_o <= '0;
      end else if (win_valid) begin
         ipl_o <= lvl;
         vec_o <= vec_d;
      end else begin
         ipl_o <= '0;
         vec_o <= '0;
      end
   end

endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc #(
   parameter int                   NUM_SRC       = 13,
   parameter int                   AW            = 8,
   parameter int                   DW            = 16,
   parameter pvic_pkg::arb_style_e ARB           = pvic_pkg::ARB_SCAN,
   parameter int                   CTRL_BASE     = 'h14,
   parameter int                   MASK_ADDR     = 'h36,
   parameter int                   PEND_ADDR     = 'h3A,
   parameter int                   WDOG_VEC_ADDR = 'h42,
   parameter int                   SER0_VEC_ADDR = 'h44,
   parameter int                   SER1_VEC_ADDR = 'h46,
   parameter int                   LVL_THRESH    = 4,
   parameter int                   AUTOVEC_BASE  = 24,
   parameter logic [7:0]           DEFAULT_VEC   = 8'h0F,
   parameter int                   WDOG_SRC      = 8,
   parameter int                   SER0_SRC      = 12,
   parameter int                   SER1_SRC      = 13
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_SRC:1]    irq_req,
   input  logic [AW-1:0]       reg_addr,
   input  logic                reg_we,
   input  logic [DW-1:0]       reg_wdata,
   output logic [DW-1:0]       reg_rdata,
   output logic [2:0]          ipl_o,
   output logic [7:0]          vec_o
);
   import pvic_pkg::*;

   localparam int IW = $clog2(NUM_SRC + 1);

   // Elaboration-time parameter checks
   if (NUM_SRC < 1 || NUM_SRC > 13) begin : g_bad_nsrc
      $error("prio_vec_intc: NUM_SRC must lie in 1..13");
   end
   if (DW < NUM_SRC + 1 || DW < 8) begin : g_bad_dw
      $error("prio_vec_intc: DW too narrow for mask or vector");
   end
   if (LVL_THRESH < 1 || LVL_THRESH > 31) begin : g_bad_thr
      $error("prio_vec_intc: LVL_THRESH out of key range");
   end
   if (CTRL_BASE + NUM_SRC > (1 << AW)) begin : g_bad_aw
      $error("prio_vec_intc: control registers exceed address space");
   end

   logic [NUM_SRC:1][7:0]     ctrl_v;
   logic [NUM_SRC:1]          mask_v;
   logic [7:0]                wvec_v, s0vec_v, s1vec_v;
   logic [NUM_SRC:1]          active_v;
   logic [NUM_SRC:1][KEY_W-1:0] keys_v;
   logic [KEY_W-1:0]          best_key;
   logic [IW-1:0]             win_idx;
   logic                      win_valid, win_auto;

   pvic_regs #(
      .NUM_SRC(NUM_SRC), .AW(AW), .DW(DW),
      .CTRL_BASE(CTRL_BASE), .MASK_ADDR(MASK_ADDR), .PEND_ADDR(PEND_ADDR),
      .WDOG_VEC_ADDR(WDOG_VEC_ADDR), .SER0_VEC_ADDR(SER0_VEC_ADDR),
      .SER1_VEC_ADDR(SER1_VEC_ADDR), .VEC_RST(DEFAULT_VEC)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .req(irq_req),
      .addr(reg_addr), .we(reg_we), .wdata(reg_wdata), .rdata(reg_rdata),
      .ctrl_o(ctrl_v), .mask_o(mask_v),
      .wvec_o(wvec_v), .s0vec_o(s0vec_v), .s1vec_o(s1vec_v)
   );

   // Eligible sources and their keys (R3, R4)
   assign active_v = irq_req & ~mask_v;
   for (genvar s = 1; s <= NUM_SRC; s++) begin : g_key
      assign keys_v[s] = ctrl_v[s][KEY_W-1:0];
   end

   pvic_arb #(
      .NUM_SRC(NUM_SRC), .IW(IW), .ARB(ARB)
   ) u_arb (
      .active(active_v), .keys(keys_v),
      .best_key(best_key), .best_idx(win_idx)
   );

   pvic_present #(
      .NUM_SRC(NUM_SRC), .IW(IW), .LVL_THRESH(LVL_THRESH),
      .AUTOVEC_BASE(AUTOVEC_BASE), .DEFAULT_VEC(DEFAULT_VEC),
      .WDOG_SRC(WDOG_SRC), .SER0_SRC(SER0_SRC), .SER1_SRC(SER1_SRC)
   ) u_present (
      .clk(clk), .rst_n(rst_n),
      .best_key(best_key), .best_idx(win_idx), .ctrl(ctrl_v),
      .wvec(wvec_v), .s0vec(s0vec_v), .s1vec(s1vec_v),
      .win_valid(win_valid), .win_auto(win_auto),
      .ipl_o(ipl_o), .vec_o(vec_o)
   );

endmodule

// File: rtl/prio_vec_intc_chk.sv
module prio_vec_intc_chk #(
   parameter int NUM_SRC      = 13,
   parameter int IW           = 4,
   parameter int AUTOVEC_BASE = 24
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC:1]   irq_req,
   input logic               reg_we,
   input logic [NUM_SRC:1]   mask_v,
   input logic               win_valid,
   input logic               win_auto,
   input logic [IW-1:0]      win_idx,
   input logic [2:0]         ipl_o,
   input logic [7:0]         vec_o
);

   logic [1:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         age <= '0;
      else if (age != 2'd2)
         age <= age + 2'd1;
   end

   logic win_live;
   always_comb begin
      win_live = 1'b0;
      for (int s = 1; s <= NUM_SRC; s++) begin
         if (win_idx == IW'(s)) win_live = irq_req[s] & ~mask_v[s];
      end
   end

   AST_WIN_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> win_live);  // R4

   AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_req & ~mask_v) == '0) |=> (ipl_o == 3'd0 && vec_o == 8'd0));  // R3

   AST_IDLE_NO_VEC: assert property (@(posedge clk) disable iff (!rst_n)
      (ipl_o == 3'd0) |-> (vec_o == 8'd0));  // R5

   AST_AUTOVEC_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && win_auto) |=> (vec_o == 8'(AUTOVEC_BASE) + {5'd0, ipl_o}));  // R7

   AST_HOLD_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd2 && !reg_we && $past(!reg_we) && $stable(irq_req))
      |=> ($stable(ipl_o) && $stable(vec_o)));  // R9

endmodule

bind prio_vec_intc prio_vec_intc_chk #(
   .NUM_SRC(NUM_SRC), .IW(IW), .AUTOVEC_BASE(AUTOVEC_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .reg_we(reg_we),
   .mask_v(mask_v), .win_valid(win_valid), .win_auto(win_auto),
   .win_idx(win_idx), .ipl_o(ipl_o), .vec_o(vec_o)
);

// File: tb/prio_vec_intc_bench.sv
`timescale 1ns/1ps
module prio_vec_intc_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [13:1] irq_req = '0;
   logic [7:0]  reg_addr = 8'hFF;
   logic        reg_we = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] rdata_a, rdata_b;
   logic [2:0]  ipl_a, ipl_b;
   logic [7:0]  vec_a, vec_b;

   int    total = 0;
   int    bad = 0;
   string cur_tag = "R1";

   always #10 clk = ~clk;

   prio_vec_intc u_prio_vec_intc (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .reg_addr(reg_addr),
      .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(rdata_a),
      .ipl_o(ipl_a), .vec_o(vec_a)
   );

   prio_vec_intc #(.ARB(pvic_pkg::ARB_TREE)) u_prio_vec_intc_tree (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .reg_addr(reg_addr),
      .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(rdata_b),
      .ipl_o(ipl_b), .vec_o(vec_b)
   );

   // ---------------- reference model ----------------
   logic [7:0]  m_ctrl [1:13];
   logic [13:1] m_mask;
   logic [7:0]  m_wv, m_s0, m_s1;
   logic [2:0]  exp_ipl;
   logic [7:0]  exp_vec;

   task automatic model_reset();
      for (int i = 1; i <= 13; i++) begin
         if (i <= 7)       m_ctrl[i] = 8'(4 * i);
         else if (i == 8)  m_ctrl[i] = 8'h1C;
         else if (i <= 11) m_ctrl[i] = 8'h80;
         else              m_ctrl[i] = 8'h00;
      end
      m_mask = '1;
      m_wv = 8'h0F;
      m_s0 = 8'h0F;
      m_s1 = 8'h0F;
   endtask

   function automatic logic [10:0] predict(input logic [13:1] rq);
      int best = 0;
      int who = 0;
      logic [2:0] lv;
      logic [7:0] vc;
      for (int i = 1; i <= 13; i++) begin
         if (rq[i] && !m_mask[i] && int'(m_ctrl[i][4:0]) > best) begin
            best = int'(m_ctrl[i][4:0]);
            who = i;
         end
      end
      if (best < 4) return 11'd0;
      lv = m_ctrl[who][4:2];
      if (m_ctrl[who][7])  vc = 8'd24 + 8'(lv);
      else if (who == 8)   vc = m_wv;
      else if (who == 12)  vc = m_s0;
      else if (who == 13)  vc = m_s1;
      else                 vc = 8'h0F;
      return {lv, vc};
   endfunction

   task automatic model_write(input logic [7:0] a, input logic [15:0] d);
      if (a >= 8'h14 && a <= 8'h20) m_ctrl[int'(a) - 'h13] = d[7:0];
      else if (a == 8'h36) m_mask = d[13:1];
      else if (a == 8'h42) m_wv = d[7:0];
      else if (a == 8'h44) m_s0 = d[7:0];
      else if (a == 8'h46) m_s1 = d[7:0];
   endtask

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // Cycle-by-cycle comparison of both instances
   always @(posedge clk) begin
      logic [10:0] nxt;
      if (!rst_n) begin
         model_reset();
         nxt = '0;
      end else begin
         nxt = predict(irq_req);
         if (reg_we) model_write(reg_addr, reg_wdata);
      end
      exp_ipl = nxt[10:8];
      exp_vec = nxt[7:0];
      #1;
      chk({cur_tag, " scan out"}, {5'd0, ipl_a, vec_a}, {5'd0, exp_ipl, exp_vec});
      chk({cur_tag, " tree out"}, {5'd0, ipl_b, vec_b}, {5'd0, exp_ipl, exp_vec});
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input logic [7:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0; reg_addr = 8'hFF;
   endtask

   task automatic rd(input string tag, input logic [7:0] a, input logic [15:0] exp);
      @(negedge clk);
      reg_addr = a;
      #1;
      chk({tag, " scan rd"}, rdata_a, exp);
      chk({tag, " tree rd"}, rdata_b, exp);
      reg_addr = 8'hFF;
   endtask

   task automatic set_req(input logic [13:1] v);
      @(negedge clk);
      irq_req = v;
   endtask

   task automatic out_is(input string tag, input logic [2:0] ipl, input logic [7:0] vec);
      repeat (2) @(negedge clk);
      #1;
      chk({tag, " scan ipl/vec"}, {5'd0, ipl_a, vec_a}, {5'd0, ipl, vec});
      chk({tag, " tree ipl/vec"}, {5'd0, ipl_b, vec_b}, {5'd0, ipl, vec});
   endtask

   function automatic logic [13:1] bit_of(input int s);
      logic [13:1] v = '0;
      v[s] = 1'b1;
      return v;
   endfunction

   // ---------------- watchdog ----------------
   initial begin
      #(200000 * 20);
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   // ---------------- test sequence ----------------
   initial begin
      logic [15:0] lfsr = 16'hACE1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values
      cur_tag = "R1";
      for (int i = 1; i <= 13; i++) begin
         logic [15:0] e;
         if (i <= 7)       e = 16'(4 * i);
         else if (i == 8)  e = 16'h1C;
         else if (i <= 11) e = 16'h80;
         else              e = 16'h00;
         rd("R1 ctrl", 8'(8'h13 + i), e);
      end
      rd("R1 mask", 8'h36, 16'h3FFE);
      rd("R1 wvec", 8'h42, 16'h000F);
      rd("R1 s0vec", 8'h44, 16'h000F);
      rd("R1 s1vec", 8'h46, 16'h000F);
      set_req(13'h1FFF);
      out_is("R1 masked idle", 3'd0, 8'h00);
      set_req('0);

      // R9: timing of presentation
      cur_tag = "R9";
      wr(8'h36, 16'h0000);
      repeat (2) @(negedge clk);
      irq_req = bit_of(1);
      #1;
      chk("R9 before edge scan", {5'd0, ipl_a, vec_a}, 16'h0000);
      chk("R9 before edge tree", {5'd0, ipl_b, vec_b}, 16'h0000);
      @(posedge clk); #2;
      chk("R9 after edge scan", {5'd0, ipl_a, vec_a}, {5'd0, 3'd1, 8'h0F});
      chk("R9 after edge tree", {5'd0, ipl_b, vec_b}, {5'd0, 3'd1, 8'h0F});
      wr(8'h1C, 16'hFF1F);
      rd("R9 ctrl upper byte", 8'h1C, 16'h001F);
      wr(8'h1C, 16'h0080);

      // R6, R8: default vector for a plain source
      cur_tag = "R6";
      set_req(bit_of(1));
      out_is("R6 src1 level", 3'd1, 8'h0F);

      // R4: tie between 7 and 8 goes to 7
      cur_tag = "R4";
      set_req(bit_of(7) | bit_of(8));
      out_is("R4 tie", 3'd7, 8'h0F);

      // R8: watchdog vector register
      cur_tag = "R8";
      set_req(bit_of(8));
      out_is("R8 wdog reset vec", 3'd7, 8'h0F);
      wr(8'h42, 16'h0055);
      out_is("R8 wdog vec", 3'd7, 8'h55);

      // R5 / R7
      cur_tag = "R5";
      set_req(bit_of(9));
      out_is("R5 key zero", 3'd0, 8'h00);
      cur_tag = "R7";
      wr(8'h1C, 16'h009F);
      set_req(bit_of(9) | bit_of(8));
      out_is("R7 autovec", 3'd7, 8'd31);

      // R8: serial vectors, tie 12/13
      cur_tag = "R8";
      wr(8'h1F, 16'h000C);
      wr(8'h20, 16'h000C);
      wr(8'h44, 16'h0040);
      wr(8'h46, 16'h0041);
      set_req(bit_of(12) | bit_of(13));
      out_is("R8 ser0 tie", 3'd3, 8'h40);
      set_req(bit_of(13));
      out_is("R8 ser1", 3'd3, 8'h41);

      // R4: priority bits within a level
      cur_tag = "R4";
      wr(8'h15, 16'h008A);
      wr(8'h17, 16'h000B);
      set_req(bit_of(2) | bit_of(4));
      out_is("R4 prio bits", 3'd2, 8'h0F);
      cur_tag = "R7";
      set_req(bit_of(2));
      out_is("R7 autovec lvl2", 3'd2, 8'd26);

      // R3: mask
      cur_tag = "R3";
      wr(8'h36, 16'h0010);
      set_req(bit_of(2) | bit_of(4));
      out_is("R3 mask one", 3'd2, 8'd26);
      wr(8'h36, 16'hFFFF);
      rd("R3 mask readback", 8'h36, 16'h3FFE);
      out_is("R3 all masked", 3'd0, 8'h00);
      wr(8'h36, 16'h0000);

      // R5: key below threshold
      cur_tag = "R5";
      wr(8'h16, 16'h0003);
      set_req(bit_of(3));
      out_is("R5 key three", 3'd0, 8'h00);

      // R2: pending view
      cur_tag = "R2";
      set_req(13'h1555);
      rd("R2 pending", 8'h3A, 16'h2AAA);
      wr(8'h3A, 16'h0000);
      rd("R2 pending after write", 8'h3A, 16'h2AAA);
      set_req(13'h0AAA);
      rd("R2 pending alt", 8'h3A, 16'h1554);

      // R10: unmapped
      cur_tag = "R10";
      wr(8'h50, 16'hFFFF);
      rd("R10 unmapped", 8'h50, 16'h0000);
      rd("R10 below ctrl", 8'h13, 16'h0000);
      rd("R10 above ctrl", 8'h21, 16'h0000);
      rd("R10 mask intact", 8'h36, 16'h0000);

      // R4: random requests and register writes, checked each clock
      cur_tag = "R4";
      for (int n = 0; n < 600; n++) begin
         @(negedge clk);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         irq_req = lfsr[13:1];
         if (lfsr[2:0] == 3'd5) begin
            logic [7:0] a;
            case (lfsr[6:4])
               3'd0:    a = 8'h36;
               3'd1:    a = 8'h42;
               3'd2:    a = 8'h44;
               3'd3:    a = 8'h46;
               default: a = 8'(8'h14 + (lfsr[11:8] % 13));
            endcase
            reg_addr = a;
            reg_wdata = {lfsr[7:0], lfsr[15:8]};
            reg_we = 1'b1;
            @(negedge clk);
            reg_we = 1'b0;
            reg_addr = 8'hFF;
         end
      end

      set_req('0);
      repeat (3) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule